// File: doc/BRIEF.md
# Lander Flight Dynamics Engine

This block keeps the flight state of a two-dimensional lander game and advances it once per video frame. Two buttons rotate the lander in fixed 5-degree steps. A third button fires the main engine while fuel remains. On every frame strobe the block takes one forward Euler step. It adds gravity and the engine's push to the velocity, and it adds the velocity to the position. It burns fuel while the engine fires. It then decides whether the game continues, the craft has touched down safely, or it has crashed.

Position and velocity are signed fixed point with 10 integer bits plus sign and 8 fractional bits. Screen coordinates grow rightward in x and downward in y, with the start point at the top-left corner. Scaling makes one frame the unit time step, so no multiply by a time step is needed. The engine's push is split into x and y parts through a small table of sine values over the 19 reachable angles from 0 to 90 degrees. The surrounding system supplies the terrain as two inputs: the ground row under the lander and a flag that marks a flat pad. These inputs are sampled on the frame strobe. Drawing, sound and timekeeping belong to other blocks.

Top module: `lander_engine`

## Requirements
- R1: While reset is asserted and just after it, position is (0,0), vel_x is 10 px/frame (2560 raw), vel_y is 0, attitude is 0, fuel is FUEL_INIT (200) and status is 0 (playing).
- R2: A rising edge on ccw_btn raises attitude by one step (5 degrees, counterclockwise positive), and a rising edge on cw_btn lowers it by one step. Holding a button gives a single step. Rising edges on both buttons in the same cycle leave attitude unchanged.
- R3: Attitude stays within -18..+18 steps (±90 degrees). A press beyond a limit has no effect.
- R4: Position, velocity and fuel change only on a cycle with frame_tick high. On that cycle x += vel_x and y += vel_y, both using the pre-update velocity.
- R5: On a frame, vel_y gains GRAV (16 raw). Let S(k) = round(256·sin(5k°)) and THRUST = 32. When the engine fires at attitude a, vel_x gains -sign(a)·floor(THRUST·S(|a|)/256) and vel_y loses floor(THRUST·S(18-|a|)/256).
- R6: The engine fires on a frame only if thrust_btn is high and fuel is nonzero. Each firing frame lowers fuel by FUEL_BURN and saturates at 0. With fuel at 0, thrust_btn has no effect.
- R7: Contact occurs when floor(new y / 256) ≥ ground_y. On contact, status becomes 1 (landed) if level_pad is high, |new vel_x| < 128 raw (0.5 px/frame) and |new vel_y| < 512 raw (2 px/frame). Otherwise status becomes 2 (crashed).
- R8: Without contact, status becomes 2 if the new x is below 0 or at or beyond 640 px, or the new y is below 0 or at or beyond 480 px.
- R9: Once status is nonzero, no output changes under any input until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle strobe that advances the simulation one step |
| cw_btn | input | 1 | Rotate clockwise button (level) |
| ccw_btn | input | 1 | Rotate counterclockwise button (level) |
| thrust_btn | input | 1 | Engine fire request (level) |
| ground_y | input | 10 | Ground row in pixels under the lander |
| level_pad | input | 1 | Ground under the lander is a flat pad |
| pos_x | output | 19 | Horizontal position, signed Q10.8 |
| pos_y | output | 19 | Vertical position, signed Q10.8, downward positive |
| vel_x | output | 19 | Horizontal velocity per frame, signed Q10.8 |
| vel_y | output | 19 | Vertical velocity per frame, signed Q10.8 |
| attitude | output | 6 | Signed attitude in 5-degree steps |
| fuel | output | 12 | Remaining fuel |
| status | output | 2 | 0 playing, 1 landed, 2 crashed |

## Verification
The hardest condition to reach from the ports is a touchdown whose speeds sit exactly on the landing limits. Random play almost never cancels the initial sideways speed. The bench therefore flies a scripted approach and uses its own model to decide when to act. It tilts the craft fully to one side and burns until the model's vel_x falls to a chosen value, 96 or 128 raw. It then levels the craft and burns until vel_y falls to a chosen value. Finally it places the ground row under the craft, so the touchdown frame lands at vel_y of 496 or 512 raw, just inside or exactly on each limit. A second instance with a tiny fuel load follows the same stimulus, so fuel saturation and firing with an empty tank occur within a few frames.

// File: rtl/lander_engine.sv
module lander_engine #(
  parameter int FRAC      = 8,
  parameter int INT_BITS  = 10,
  parameter int ATT_MAX   = 18,
  parameter int SCR_W     = 640,
  parameter int SCR_H     = 480,
  parameter int GRAV      = 16,
  parameter int THRUST    = 2 * GRAV,
  parameter int VX0       = 10,
  parameter int FUEL_INIT = 200,
  parameter int FUEL_BURN = 1,
  parameter int FUEL_W    = 12,
  parameter int VX_LIM    = 128,
  parameter int VY_LIM    = 512,
  parameter int GY_W      = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          frame_tick,
  input  logic                          cw_btn,
  input  logic                          ccw_btn,
  input  logic                          thrust_btn,
  input  logic [GY_W-1:0]               ground_y,
  input  logic                          level_pad,
  output logic signed [INT_BITS+FRAC:0] pos_x,
  output logic signed [INT_BITS+FRAC:0] pos_y,
  output logic signed [INT_BITS+FRAC:0] vel_x,
  output logic signed [INT_BITS+FRAC:0] vel_y,
  output logic signed [$clog2(ATT_MAX+1):0] attitude,
  output logic [FUEL_W-1:0]             fuel,
  output logic [1:0]                    status
);
  localparam int W       = INT_BITS + FRAC + 1;
  localparam int WW      = W + 2;
  localparam int AW      = $clog2(ATT_MAX + 1) + 1;
  localparam int QUARTER = 18;
  localparam int TRIG_Q  = 8;

  localparam logic [1:0] ST_PLAY  = 2'd0;
  localparam logic [1:0] ST_LAND  = 2'd1;
  localparam logic [1:0] ST_CRASH = 2'd2;

  localparam logic signed [AW-1:0] ATT_HI = AW'(ATT_MAX);
  localparam logic signed [AW-1:0] ATT_LO = -ATT_HI;
  localparam logic signed [WW-1:0] X_END  = WW'(SCR_W * (2 ** FRAC));
  localparam logic signed [WW-1:0] Y_END  = WW'(SCR_H * (2 ** FRAC));
  localparam logic signed [WW-1:0] VXL    = WW'(VX_LIM);
  localparam logic signed [WW-1:0] VYL    = WW'(VY_LIM);

  function automatic int sin_q(input int k);
    case (k)
      0: return 0;     1: return 22;    2: return 44;    3: return 66;
      4: return 88;    5: return 108;   6: return 128;   7: return 147;
      8: return 165;   9: return 181;   10: return 196;  11: return 210;
      12: return 222;  13: return 232;  14: return 241;  15: return 247;
      16: return 252;  17: return 255;  default: return 256;
    endcase
  endfunction

  logic signed [W-1:0]  x_r, y_r, vx_r, vy_r;
  logic signed [AW-1:0] att_r;
  logic [FUEL_W-1:0]    fuel_r;
  logic [1:0]           st_r;
  logic                 cw_q, ccw_q;

  wire cw_rise  = cw_btn & ~cw_q;
  wire ccw_rise = ccw_btn & ~ccw_q;
  wire burn     = thrust_btn && (fuel_r != '0);

  logic [AW-1:0]        att_mag;
  logic signed [WW-1:0] tx, ty, ax, ay;
  logic signed [WW-1:0] x_n, y_n, vx_n, vy_n, y_int, gnd, vx_abs, vy_abs;
  logic [FUEL_W-1:0]    fuel_n;
  logic                 contact, off_scr, safe;
  logic [1:0]           st_n;

  always_comb begin
    att_mag = att_r[AW-1] ? AW'(-att_r) : AW'(att_r);
    tx = WW'((THRUST * sin_q(int'(att_mag))) >>> TRIG_Q);
    ty = WW'((THRUST * sin_q(QUARTER - int'(att_mag))) >>> TRIG_Q);
    ax = !burn ? '0 : ((att_r > 0) ? -tx : tx);
    ay = WW'(GRAV) - (burn ? ty : '0);

    x_n  = WW'(x_r) + WW'(vx_r);
    y_n  = WW'(y_r) + WW'(vy_r);
    vx_n = WW'(vx_r) + ax;
    vy_n = WW'(vy_r) + ay;

    fuel_n = fuel_r;
    if (burn) fuel_n = (fuel_r > FUEL_W'(FUEL_BURN)) ? fuel_r - FUEL_W'(FUEL_BURN) : '0;

    y_int   = y_n >>> FRAC;
    gnd     = $signed({{(WW-GY_W){1'b0}}, ground_y});
    contact = (y_int >= gnd);
    off_scr = (x_n < 0) || (x_n >= X_END) || (y_n < 0) || (y_n >= Y_END);
    vx_abs  = vx_n[WW-1] ? -vx_n : vx_n;
    vy_abs  = vy_n[WW-1] ? -vy_n : vy_n;
    safe    = level_pad && (vx_abs < VXL) && (vy_abs < VYL);

    if (contact)      st_n = safe ? ST_LAND : ST_CRASH;
    else if (off_scr) st_n = ST_CRASH;
    else              st_n = ST_PLAY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_r    <= '0;
      y_r    <= '0;
      vx_r   <= W'(VX0 * (2 ** FRAC));
      vy_r   <= '0;
      att_r  <= '0;
      fuel_r <= FUEL_W'(FUEL_INIT);
      st_r   <= ST_PLAY;
      cw_q   <= 1'b0;
      ccw_q  <= 1'b0;
    end else begin
      cw_q  <= cw_btn;
      ccw_q <= ccw_btn;
      if (st_r == ST_PLAY) begin
        if (ccw_rise && !cw_rise && att_r < ATT_HI)      att_r <= att_r + AW'(1);
        else if (cw_rise && !ccw_rise && att_r > ATT_LO) att_r <= att_r - AW'(1);
        if (frame_tick) begin
          x_r    <= x_n[W-1:0];
          y_r    <= y_n[W-1:0];
          vx_r   <= vx_n[W-1:0];
          vy_r   <= vy_n[W-1:0];
          fuel_r <= fuel_n;
          st_r   <= st_n;
        end
      end
    end
  end

  assign pos_x    = x_r;
  assign pos_y    = y_r;
  assign vel_x    = vx_r;
  assign vel_y    = vy_r;
  assign attitude = att_r;
  assign fuel     = fuel_r;
  assign status   = st_r;
endmodule

// File: rtl/lander_engine_chk.sv
module lander_engine_chk #(
  parameter int FRAC     = 8,
  parameter int INT_BITS = 10,
  parameter int ATT_MAX  = 18,
  parameter int GRAV     = 16,
  parameter int FUEL_W   = 12
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          frame_tick,
  input logic                          level_pad,
  input logic signed [INT_BITS+FRAC:0] pos_x,
  input logic signed [INT_BITS+FRAC:0] pos_y,
  input logic signed [INT_BITS+FRAC:0] vel_x,
  input logic signed [INT_BITS+FRAC:0] vel_y,
  input logic signed [$clog2(ATT_MAX+1):0] attitude,
  input logic [FUEL_W-1:0]             fuel,
  input logic [1:0]                    status
);
  localparam int W = INT_BITS + FRAC + 1;

  // R3
  att_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(attitude) <= ATT_MAX) && (int'(attitude) >= -ATT_MAX));

  // R2
  att_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((int'(attitude) - int'($past(attitude))) <= 1) &&
             ((int'(attitude) - int'($past(attitude))) >= -1));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(pos_x) && $stable(pos_y) && $stable(vel_x) &&
                    $stable(vel_y) && $stable(fuel));

  // R6
  fuel_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fuel <= $past(fuel));

  // R6
  empty_tank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && status == 2'd0 && fuel == '0 && attitude == '0)
      |=> vel_y == $past(vel_y) + W'(GRAV));

  // R7
  land_needs_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd0 && !(frame_tick && level_pad)) |=> status != 2'd1);

  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'd0) |=> $stable(pos_x) && $stable(pos_y) && $stable(vel_x) &&
                        $stable(vel_y) && $stable(attitude) && $stable(fuel) &&
                        $stable(status));
endmodule

bind lander_engine lander_engine_chk #(
  .FRAC(FRAC), .INT_BITS(INT_BITS), .ATT_MAX(ATT_MAX), .GRAV(GRAV), .FUEL_W(FUEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .level_pad(level_pad),
  .pos_x(pos_x), .pos_y(pos_y), .vel_x(vel_x), .vel_y(vel_y),
  .attitude(attitude), .fuel(fuel), .status(status)
);

// File: tb/lander_engine_bench.sv
`timescale 1ns/1ps
module lander_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0, frame_tick = 1'b0;
  logic cw = 1'b0, ccw = 1'b0, thr = 1'b0, level = 1'b0;
  logic [9:0] ground_y = 10'd1023;

  logic signed [18:0] ax_p, ay_p, avx, avy, bx_p, by_p, bvx, bvy;
  logic signed [5:0]  aatt, batt;
  logic [11:0]        afuel, bfuel;
  logic [1:0]         ast, bst;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lander_engine u_lander_engine (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .cw_btn(cw), .ccw_btn(ccw),
    .thrust_btn(thr), .ground_y(ground_y), .level_pad(level),
    .pos_x(ax_p), .pos_y(ay_p), .vel_x(avx), .vel_y(avy),
    .attitude(aatt), .fuel(afuel), .status(ast));

  lander_engine #(.FUEL_INIT(7), .FUEL_BURN(2)) u_lander_engine_lf (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .cw_btn(cw), .ccw_btn(ccw),
    .thrust_btn(thr), .ground_y(ground_y), .level_pad(level),
    .pos_x(bx_p), .pos_y(by_p), .vel_x(bvx), .vel_y(bvy),
    .attitude(batt), .fuel(bfuel), .status(bst));

  typedef struct {int x; int y; int vx; int vy; int att; int fuel; int st; int burn_amt;} mst_t;
  mst_t ma, mb;

  function automatic int stab(int k);
    return int'($floor(256.0 * $sin(real'(k) * 5.0 * 3.14159265358979 / 180.0) + 0.5));
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic mst_t m_reset(int f0, int b);
    mst_t s;
    s.x = 0; s.y = 0; s.vx = 2560; s.vy = 0; s.att = 0;
    s.fuel = f0; s.st = 0; s.burn_amt = b;
    return s;
  endfunction

  function automatic mst_t m_press(mst_t s, bit up, bit dn);
    if (s.st != 0 || (up && dn)) return s;
    if (up && s.att < 18) s.att++;
    if (dn && s.att > -18) s.att--;
    return s;
  endfunction

  function automatic mst_t m_frame(mst_t s, bit t, int gy, bit lvl);
    mst_t n;
    bit b;
    int am, tx, ty, ax, ay;
    if (s.st != 0) return s;
    n = s;
    b = t && (s.fuel != 0);
    am = iabs(s.att);
    tx = b ? (32 * stab(am)) / 256 : 0;
    ty = b ? (32 * stab(18 - am)) / 256 : 0;
    ax = (s.att > 0) ? -tx : tx;
    ay = 16 - ty;
    n.x = s.x + s.vx; n.y = s.y + s.vy;
    n.vx = s.vx + ax; n.vy = s.vy + ay;
    if (b) n.fuel = (s.fuel > s.burn_amt) ? s.fuel - s.burn_amt : 0;
    if ((n.y >>> 8) >= gy)
      n.st = (lvl && iabs(n.vx) < 128 && iabs(n.vy) < 512) ? 1 : 2;
    else if (n.x < 0 || n.x >= 640 * 256 || n.y < 0 || n.y >= 480 * 256)
      n.st = 2;
    return n;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    string t4, t5, t2, t6, t7;
    t4 = (tag == "") ? "R4" : tag; t5 = (tag == "") ? "R5" : tag;
    t2 = (tag == "") ? "R2" : tag; t6 = (tag == "") ? "R6" : tag;
    t7 = (tag == "") ? "R7" : tag;
    chk(t4, "A pos_x", int'(ax_p), ma.x);   chk(t4, "A pos_y", int'(ay_p), ma.y);
    chk(t5, "A vel_x", int'(avx), ma.vx);   chk(t5, "A vel_y", int'(avy), ma.vy);
    chk(t2, "A att", int'(aatt), ma.att);   chk(t6, "A fuel", int'(afuel), ma.fuel);
    chk(t7, "A status", int'(ast), ma.st);
    chk(t4, "B pos_x", int'(bx_p), mb.x);   chk(t4, "B pos_y", int'(by_p), mb.y);
    chk(t5, "B vel_x", int'(bvx), mb.vx);   chk(t5, "B vel_y", int'(bvy), mb.vy);
    chk(t2, "B att", int'(batt), mb.att);   chk(t6, "B fuel", int'(bfuel), mb.fuel);
    chk(t7, "B status", int'(bst), mb.st);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cw = 0; ccw = 0; thr = 0; frame_tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ma = m_reset(200, 1);
    mb = m_reset(7, 2);
    @(negedge clk);
  endtask

  task automatic press(bit up, bit dn);
    @(negedge clk);
    ccw = up; cw = dn;
    @(negedge clk);
    ccw = 0; cw = 0;
    ma = m_press(ma, up, dn);
    mb = m_press(mb, up, dn);
  endtask

  task automatic frame(bit t);
    @(negedge clk);
    thr = t; frame_tick = 1'b1;
    @(negedge clk);
    thr = 0; frame_tick = 1'b0;
    ma = m_frame(ma, t, int'(ground_y), level);
    mb = m_frame(mb, t, int'(ground_y), level);
  endtask

  task automatic approach(int vx_stop, int vy_stop, bit lvl, int exp_st);
    do_reset();
    ground_y = 10'd1023; level = 1'b0;
    for (int i = 0; i < 18; i++) press(1, 0);
    for (int i = 0; i < 120 && ma.vx > vx_stop; i++) frame(1);
    for (int i = 0; i < 18; i++) press(0, 1);
    for (int i = 0; i < 200 && ma.vy > vy_stop; i++) frame(1);
    check_all("");
    ground_y = 10'(ma.y >>> 8);
    level = lvl;
    frame(0);
    check_all("R7");
    chk("R7", "touchdown status", int'(ast), exp_st);
    ground_y = 10'd1023; level = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    do_reset();
    // R1 reset values
    check_all("R1");
    chk("R1", "A vel_x", int'(avx), 2560);
    chk("R1", "A fuel", int'(afuel), 200);

    // R2 single steps, held button, simultaneous edges
    press(1, 0); check_all("R2"); chk("R2", "att after ccw", int'(aatt), 1);
    press(0, 1); press(0, 1); check_all("R2"); chk("R2", "att after 2 cw", int'(aatt), -1);
    @(negedge clk); ccw = 1;
    repeat (6) @(negedge clk);
    ccw = 0;
    ma = m_press(ma, 1, 0); mb = m_press(mb, 1, 0);
    @(negedge clk);
    check_all("R2"); chk("R2", "held ccw one step", int'(aatt), 0);
    press(1, 1); check_all("R2"); chk("R2", "both edges", int'(aatt), 0);

    // R3 saturation
    for (int i = 0; i < 25; i++) press(1, 0);
    check_all("R3"); chk("R3", "ccw limit", int'(aatt), 18);
    for (int i = 0; i < 40; i++) press(0, 1);
    check_all("R3"); chk("R3", "cw limit", int'(aatt), -18);

    // R8 drift off the right edge
    do_reset();
    ground_y = 10'd1023; level = 1'b0;
    for (int i = 0; i < 100 && ma.st == 0; i++) frame(0);
    check_all("R8"); chk("R8", "off screen status", int'(ast), 2);
    // R9 frozen after end
    press(1, 0); frame(1); press(0, 1); frame(0);
    check_all("R9");

    // R6 fuel drain, saturation, empty tank
    do_reset();
    repeat (4) frame(0);
    repeat (4) frame(1);
    check_all("R6");
    chk("R6", "A fuel", int'(afuel), 196);
    chk("R6", "B fuel saturated", int'(bfuel), 0);
    frame(1);
    check_all("R6");

    // R5 thrust vectoring at several attitudes
    do_reset();
    press(1, 0); press(1, 0); press(1, 0); frame(0); frame(1); check_all("R5");
    for (int i = 0; i < 9; i++) press(0, 1);
    frame(1); check_all("R5");

    // R7 touchdown limits
    approach(96, 0, 1'b1, 1);
    approach(128, 0, 1'b1, 2);
    approach(96, 496, 1'b1, 2);
    approach(96, 480, 1'b1, 1);
    approach(96, 0, 1'b0, 2);

    // random games
    for (int g = 0; g < 30; g++) begin
      do_reset();
      ground_y = 10'($urandom_range(60, 470));
      level = 1'($urandom_range(0, 1));
      for (int f = 0; f < 150 && (ma.st == 0 || mb.st == 0); f++) begin
        int r;
        r = $urandom_range(0, 9);
        if (r < 2) press(1, 0);
        else if (r < 4) press(0, 1);
        else if (r == 4) press(1, 1);
        frame(1'($urandom_range(0, 1)));
        check_all("");
      end
      for (int k = 0; k < 3; k++) begin
        press(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        frame(1);
        if (ma.st != 0 && mb.st != 0) check_all("R9");
        else check_all("");
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule